// File: doc/BRIEF.md
# Audio Frame Sequencer with Frame Interrupt

This block paces the slow-rate control units of a sound generator. A tick enable arrives once every second CPU cycle. The block counts these ticks and, at fixed but irregular tick counts, pulses two strobes. The quarter-frame strobe drives the envelope and linear-counter units. The half-frame strobe drives the length-counter and sweep units. The sound channels that consume these strobes are outside this block.

Software picks a four-step or a five-step sequence with a control byte write, and can also inhibit the frame interrupt. In four-step mode the block raises a frame interrupt level at the end of each sequence. That level stays high until a status read or an inhibiting write clears it. Every port is a plain control or status pin, so there is no flow control at the edge of the block. Each input is sampled on the rising clock edge. The strobes and the interrupt are registered, so they respond one clock after the edge that sampled their cause.

Top module: `afs_sequencer`

## Requirements
- R1: After reset, qtr_o, half_o and irq_o are 0, the mode is four-step, the inhibit is clear and the tick count is 0.
- R2: The tick count advances only on cycles with tick_en high and no control write. A step fires when a counted tick finds the count equal to one of the boundaries STEP0..STEP4, which are step indices 0..4. No strobe fires on any other cycle, except for the mode-select write in R8.
- R3: In four-step mode the count returns to 0 after the tick at STEP3, so the sequence repeats every STEP3+1 ticks. In five-step mode it returns to 0 after the tick at STEP4, so the sequence repeats every STEP4+1 ticks.
- R4: qtr_o pulses for one cycle on every step, except step index 3 in five-step mode.
- R5: half_o pulses for one cycle on step index 1, on step index 3 in four-step mode, and on step index 4 in five-step mode. It never pulses without qtr_o.
- R6: The interrupt flag is set on step index 3 in four-step mode when the inhibit is clear. It is never set in five-step mode.
- R7: A control write (ctl_we high) loads the mode from ctl_wdata bit 7 (0 selects four-step, 1 selects five-step) and the inhibit from ctl_wdata bit 6. It also resets the tick count to 0. A tick on the same cycle is discarded.
- R8: A control write with bit 7 set pulses qtr_o and half_o together on the next cycle. A write with bit 7 clear pulses neither.
- R9: stat_rd clears the interrupt flag. If the flag is set on the same cycle, the set wins.
- R10: A control write with bit 6 set clears a pending interrupt flag at once.
- R11: irq_o is a registered level. Once set, it stays high until R9 or R10 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Sequencer tick enable, one clock wide |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control byte: bit 7 selects the mode, bit 6 is the inhibit |
| stat_rd | input | 1 | Status read strobe that clears the frame interrupt |
| qtr_o | output | 1 | Quarter-frame strobe |
| half_o | output | 1 | Half-frame strobe |
| irq_o | output | 1 | Frame interrupt level |

## Verification
The bench builds the sequencer with the step boundaries scaled down to 6, 12, 19, 25 and 31 ticks. These keep the same uneven spacing as the defaults. With them, several complete four-step and five-step sequences, and their wrap points, fit in a few hundred cycles. The short frames make it cheap to cover these cases:
- a tick on the same cycle as a write;
- a status read on the same cycle as the interrupt step;
- a restart in the middle of a frame;
- tick spacings of every cycle, every second cycle and every third cycle.

// File: rtl/afs_pkg.sv
package afs_pkg;

  typedef enum logic {
    MODE_FOUR = 1'b0,
    MODE_FIVE = 1'b1
  } afs_mode_e;

  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned INH_BIT  = 6;
  localparam int unsigned NSTEP    = 5;

  typedef struct packed {
    logic quarter;
    logic half;
    logic irq_set;
  } afs_evt_t;

endpackage

// File: rtl/afs_tick_timer.sv
module afs_tick_timer
  import afs_pkg::*;
#(
  parameter int unsigned S0 = 3728,
  parameter int unsigned S1 = 7456,
  parameter int unsigned S2 = 11185,
  parameter int unsigned S3 = 14914,
  parameter int unsigned S4 = 18640
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  afs_mode_e        mode,
  output logic [NSTEP-1:0] hit
);

  localparam int unsigned CW = $clog2(S4 + 2);
  localparam logic [CW-1:0] BND [NSTEP] = '{CW'(S0), CW'(S1), CW'(S2), CW'(S3), CW'(S4)};

  logic [CW-1:0] cnt;
  logic [CW-1:0] wrap_at;
  logic          adv;

  assign adv     = tick_en & ~restart;
  assign wrap_at = (mode == MODE_FIVE) ? BND[4] : BND[3];

  for (genvar i = 0; i < NSTEP; i++) begin : g_match
    assign hit[i] = adv & (cnt == BND[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (tick_en) begin
      cnt <= (cnt == wrap_at) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/afs_step_decode.sv
module afs_step_decode
  import afs_pkg::*;
(
  input  logic [NSTEP-1:0] hit,
  input  afs_mode_e        mode,
  input  logic             inhibit,
  input  logic             force_both,
  output afs_evt_t         evt
);

  logic five;
  assign five = (mode == MODE_FIVE);

  always_comb begin
    evt.quarter = force_both | hit[0] | hit[1] | hit[2] | (hit[3] & ~five) | hit[4];
    evt.half    = force_both | hit[1] | (hit[3] & ~five) | (hit[4] & five);
    evt.irq_set = hit[3] & ~five & ~inhibit;
  end

endmodule

// File: rtl/afs_irq_flag.sv
module afs_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/afs_sequencer.sv
module afs_sequencer
  import afs_pkg::*;
#(
  parameter int unsigned STEP0 = 3728,
  parameter int unsigned STEP1 = 7456,
  parameter int unsigned STEP2 = 11185,
  parameter int unsigned STEP3 = 14914,
  parameter int unsigned STEP4 = 18640
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       stat_rd,
  output logic       qtr_o,
  output logic       half_o,
  output logic       irq_o
);

  afs_mode_e        mode_q;
  logic             inh_q;
  logic [NSTEP-1:0] hit;
  afs_evt_t         evt;
  logic             mode5_wr;
  logic             irq_clr;

  assign mode5_wr = ctl_we & ctl_wdata[MODE_BIT];
  assign irq_clr  = stat_rd | (ctl_we & ctl_wdata[INH_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FOUR;
      inh_q  <= 1'b0;
    end else if (ctl_we) begin
      mode_q <= afs_mode_e'(ctl_wdata[MODE_BIT]);
      inh_q  <= ctl_wdata[INH_BIT];
    end
  end

  afs_tick_timer #(
    .S0(STEP0), .S1(STEP1), .S2(STEP2), .S3(STEP3), .S4(STEP4)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .restart (ctl_we),
    .mode    (mode_q),
    .hit     (hit)
  );

  afs_step_decode u_dec (
    .hit        (hit),
    .mode       (mode_q),
    .inhibit    (inh_q),
    .force_both (mode5_wr),
    .evt        (evt)
  );

  afs_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt.irq_set),
    .clr   (irq_clr),
    .flag  (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtr_o  <= 1'b0;
      half_o <= 1'b0;
    end else begin
      qtr_o  <= evt.quarter;
      half_o <= evt.half;
    end
  end

endmodule

// File: rtl/afs_checker.sv
module afs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic       stat_rd,
  input logic       qtr_o,
  input logic       half_o,
  input logic       irq_o
);

  a_r8_mode5_write_both: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[7] |=> qtr_o && half_o);

  a_r8_mode4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !ctl_wdata[7] |=> !qtr_o && !half_o);

  a_r2_no_tick_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !ctl_we |=> !qtr_o && !half_o);

  a_r5_half_with_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    half_o |-> qtr_o);

  a_r6_irq_rise_on_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> half_o && qtr_o);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !tick_en |=> !irq_o);

  a_r10_inhibit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[6] |=> !irq_o);

  a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !stat_rd && !(ctl_we && ctl_wdata[6]) |=> irq_o);

endmodule

bind afs_sequencer afs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .stat_rd   (stat_rd),
  .qtr_o     (qtr_o),
  .half_o    (half_o),
  .irq_o     (irq_o)
);

// File: tb/sim_afs_sequencer.sv
`timescale 1ns/1ps
module sim_afs_sequencer;

  localparam int B0 = 6, B1 = 12, B2 = 19, B3 = 25, B4 = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       stat_rd = 1'b0;
  logic       qtr_o, half_o, irq_o;

  always #10 clk = ~clk;

  afs_sequencer #(
    .STEP0(B0), .STEP1(B1), .STEP2(B2), .STEP3(B3), .STEP4(B4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
    .qtr_o(qtr_o), .half_o(half_o), .irq_o(irq_o)
  );

  typedef struct {
    int    due;
    bit    q;
    bit    h;
    bit    irq;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  // Reference state, kept from the requirements
  int mcnt = 0;
  bit mfive = 1'b0;
  bit minh = 1'b0;
  bit mirq = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %s expected %s (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops each expected item on its due cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check(qtr_o == e.q && half_o == e.h && irq_o == e.irq, e.tag,
            $sformatf("q=%0b h=%0b irq=%0b", qtr_o, half_o, irq_o),
            $sformatf("q=%0b h=%0b irq=%0b", e.q, e.h, e.irq));
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic drive(input bit tk, input bit wr, input logic [7:0] d, input bit rd);
    exp_t e;
    bit   setf;
    int   idx;
    int   last;
    @(posedge clk);
    #1;
    tick_en = tk; ctl_we = wr; ctl_wdata = d; stat_rd = rd;
    e.q = 0; e.h = 0; setf = 0; e.tag = "R2 R11 idle";
    if (wr) begin
      mcnt  = 0;
      mfive = d[7];
      minh  = d[6];
      e.q = d[7]; e.h = d[7];
      if (d[6]) mirq = 0;
      e.tag = "R7 R8 R10 write";
    end else if (tk) begin
      idx = -1;
      if (mcnt == B0) idx = 0;
      if (mcnt == B1) idx = 1;
      if (mcnt == B2) idx = 2;
      if (mcnt == B3) idx = 3;
      if (mcnt == B4) idx = 4;
      if (idx >= 0) begin
        e.q  = !(mfive && idx == 3);
        e.h  = (idx == 1) || (!mfive && idx == 3) || (mfive && idx == 4);
        setf = !mfive && idx == 3 && !minh;
        e.tag = "R2 R3 R4 R5 R6 step";
      end else begin
        e.tag = "R2 R3 tick";
      end
      last = mfive ? B4 : B3;
      mcnt = (mcnt == last) ? 0 : mcnt + 1;
    end
    if (setf) mirq = 1;
    else if (rd) begin
      mirq = 0;
      e.tag = {e.tag, " R9 read"};
    end
    e.irq = mirq;
    e.due = cyc + 1;
    exp_q.push_back(e);
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, 8'h00, 1'b0);
      for (int g = 0; g < gap; g++) drive(1'b0, 1'b0, 8'h00, 1'b0);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(qtr_o == 0, "R1 reset qtr", $sformatf("%0b", qtr_o), "0");
    check(half_o == 0, "R1 reset half", $sformatf("%0b", half_o), "0");
    check(irq_o == 0, "R1 reset irq", $sformatf("%0b", irq_o), "0");
    @(posedge clk); #1 rst_n = 1'b1;

    run(60, 1);                              // four-step, tick every second cycle
    drive(1'b0, 1'b0, 8'h00, 1'b1);          // R9 read clears
    drive(1'b1, 1'b1, 8'h40, 1'b0);          // inhibit, tick discarded
    run(30, 0);                              // no interrupt while inhibited
    drive(1'b0, 1'b1, 8'h00, 1'b0);
    run(26, 0);                              // interrupt at index 3
    run(3, 0);                               // held level, R11
    drive(1'b0, 1'b1, 8'h40, 1'b0);          // R10 inhibit write clears
    drive(1'b0, 1'b1, 8'h00, 1'b0);
    run(25, 0);
    drive(1'b1, 1'b0, 8'h00, 1'b1);          // set and read together: set wins
    run(2, 0);
    drive(1'b0, 1'b1, 8'h80, 1'b0);          // five-step, both strobes now
    run(70, 2);
    drive(1'b1, 1'b1, 8'hC0, 1'b0);          // write with tick
    run(40, 0);
    drive(1'b0, 1'b1, 8'h00, 1'b0);
    run(10, 0);
    drive(1'b0, 1'b1, 8'h00, 1'b0);          // mid-frame restart, R7
    run(30, 0);
    repeat (3) drive(1'b0, 1'b0, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R2 actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule